// File: doc/BRIEF.md
# Cell Lookup Address Generator

This block turns the routing fields of a received cell header into the byte address of that cell's 8-byte lookup entry in external memory. Three input ports share it. Each port carries its own settings: a 32-bit table base, a table-size code selecting a 17, 18, 19 or 20 bit index, and a count of VCI bits that go into the index. The index puts the chosen number of VCI low bits at the bottom and fills the rest from VPI low bits. It is scaled by eight and added to the port's base.

A header comes in with a port code, a 12-bit VPI and a 16-bit VCI under a valid/ready handshake. One clock later the address is presented with a valid strobe. It is held until the consumer takes it. Settings that cannot be met, because they need more VPI or VCI bits than the header carries, or because they name a port that does not exist, raise an error flag in place of an address. A carry out of the 32-bit sum raises an overflow flag.

The output stage is a two-state machine. ST_EMPTY holds no result. ST_FULL holds one result. Its transitions are:
- T_LOAD: ST_EMPTY to ST_FULL, when a header is accepted.
- T_STALL: ST_FULL stays in ST_FULL, when the consumer is not ready.
- T_REFILL: ST_FULL stays in ST_FULL, when the result is taken and a new header is accepted in the same cycle.
- T_DRAIN: ST_FULL to ST_EMPTY, when the result is taken and no header arrives.

Top module: `cell_lut_addr_gen`

## Requirements
- R1: After reset `out_valid` is low and `hdr_ready` is high. Every port starts with base 0, size code 0 and a VCI bit count of 16.
- R2: A setting is written by pulsing `cfg_we` for one clock. `cfg_port` holds 0, 1 or 2 to pick the port, and `cfg_sel` picks the setting: 0 for the base (`cfg_wdata[31:0]`), 1 for the size code (`cfg_wdata[1:0]`), 2 for the VCI bit count (`cfg_wdata[4:0]`). A write with `cfg_port`=3 or `cfg_sel`=3 changes no setting.
- R3: The index width is 17 plus the port's size code. Index bits at and above that width are zero.
- R4: The lowest n index bits equal VCI bits n-1..0, where n is the port's VCI bit count.
- R5: The index bits from n up to the index width minus one equal VPI bits starting at bit 0.
- R6: `out_addr` equals (base + index×8) mod 2^32. `out_ovf` is high exactly when that sum carries out of bit 31.
- R7: A lookup sets `out_cfg_err` when any of these holds: n > 16, the index width exceeds n + 12, or the port code is 3. In that case `out_addr` is 0 and `out_ovf` is low.
- R8: A header taken at a rising edge (`hdr_valid` and `hdr_ready` both high) has its result on the outputs, with `out_valid` high, right after that edge. `out_valid` never rises without such an acceptance.
- R9: While `out_valid` is high and `out_ready` is low, the result stays unchanged and `hdr_ready` is low.
- R10: With `out_ready` held high, a new header can be accepted on every clock, giving one result per clock.
- R11: A write to one port's settings leaves the results of the other ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_port | input | 2 | Port whose setting is written |
| cfg_sel | input | 2 | Setting selector: 0 base, 1 size code, 2 VCI count |
| cfg_wdata | input | 32 | Write data |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Block can take a header |
| hdr_port | input | 2 | Port the header arrived on |
| hdr_vpi | input | 12 | Header VPI |
| hdr_vci | input | 16 | Header VCI |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Entry byte address |
| out_cfg_err | output | 1 | Settings cannot be met for this lookup |
| out_ovf | output | 1 | Address sum carried out of 32 bits |

## Verification
Most faults in the settings storage or in the index builder do not stay hidden. They show up in `out_addr` on the first clock after the affected header is accepted. A misplaced VPI/VCI boundary moves specific address bits, and a wrong width check flips `out_cfg_err` on the same cycle. A fault in the output state machine shows up in the handshake instead. A result may be dropped or replaced during a stall, or `out_valid` may appear without an accepted header. Either one is visible within one or two clocks of the stall or of the acceptance.

// File: rtl/lut_addr_pkg.sv
package lut_addr_pkg;

    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned VPI_W     = 12;
    localparam int unsigned VCI_W     = 16;
    localparam int unsigned IDX_MIN   = 17;
    localparam int unsigned SIZE_W    = 2;
    localparam int unsigned IDX_MAX   = IDX_MIN + (1 << SIZE_W) - 1;
    localparam int unsigned CNT_W     = 5;
    localparam int unsigned PORT_W    = 2;
    localparam int unsigned SEL_W     = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_BASE = 2'd0,
        SEL_SIZE = 2'd1,
        SEL_VCNT = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic [CNT_W-1:0]  vcnt;
    } port_cfg_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/lut_cfg_bank.sv
module lut_cfg_bank
    import lut_addr_pkg::*;
#(
    parameter int unsigned NPORTS    = 3,
    parameter int unsigned VCNT_INIT = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [PORT_W-1:0]             wport,
    input  logic [SEL_W-1:0]              wsel,
    input  logic [ADDR_W-1:0]             wdata,
    output port_cfg_t [NPORTS-1:0]        cfg_o
);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        port_cfg_t cfg_q;
        logic      hit;

        assign hit = we && (wport == PORT_W'(p));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q.base <= '0;
                cfg_q.size <= '0;
                cfg_q.vcnt <= CNT_W'(VCNT_INIT);
            end else if (hit) begin
                unique case (cfg_sel_e'(wsel))
                    SEL_BASE: cfg_q.base <= wdata;
                    SEL_SIZE: cfg_q.size <= wdata[SIZE_W-1:0];
                    SEL_VCNT: cfg_q.vcnt <= wdata[CNT_W-1:0];
                    SEL_NONE: cfg_q      <= cfg_q;
                endcase
            end
        end

        assign cfg_o[p] = cfg_q;
    end

endmodule

// File: rtl/lut_key_build.sv
module lut_key_build
    import lut_addr_pkg::*;
(
    input  logic [SIZE_W-1:0]  size,
    input  logic [CNT_W-1:0]   vcnt,
    input  logic [VPI_W-1:0]   vpi,
    input  logic [VCI_W-1:0]   vci,
    output logic [IDX_MAX-1:0] key,
    output logic               bad
);

    localparam int unsigned WW = 6;

    logic [WW-1:0]      idx_w;
    logic [WW-1:0]      room;
    logic [IDX_MAX-1:0] vpi_ext;
    logic [IDX_MAX-1:0] vci_ext;
    logic [IDX_MAX-1:0] vpi_sh;

    always_comb begin
        idx_w   = WW'(IDX_MIN) + WW'(size);
        room    = WW'(vcnt) + WW'(VPI_W);
        bad     = (vcnt > CNT_W'(VCI_W)) || (idx_w > room);
        vpi_ext = IDX_MAX'(vpi);
        vci_ext = IDX_MAX'(vci);
        vpi_sh  = vpi_ext << vcnt;
    end

    for (genvar i = 0; i < IDX_MAX; i++) begin : g_bit
        always_comb begin
            if (WW'(i) >= idx_w) begin
                key[i] = 1'b0;
            end else if (CNT_W'(i) < vcnt) begin
                key[i] = vci_ext[i];
            end else begin
                key[i] = vpi_sh[i];
            end
        end
    end

endmodule

// File: rtl/lut_addr_sum.sv
module lut_addr_sum
    import lut_addr_pkg::*;
#(
    parameter int unsigned ENTRY_SHIFT = 3
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [IDX_MAX-1:0] key,
    output logic [ADDR_W-1:0]  addr,
    output logic               carry
);

    logic [ADDR_W:0] scaled;
    logic [ADDR_W:0] total;

    always_comb begin
        scaled = (ADDR_W+1)'(key) << ENTRY_SHIFT;
        total  = {1'b0, base} + scaled;
        addr   = total[ADDR_W-1:0];
        carry  = total[ADDR_W];
    end

endmodule

// File: rtl/cell_lut_addr_gen.sv
module cell_lut_addr_gen
    import lut_addr_pkg::*;
#(
    parameter int unsigned NPORTS      = 3,
    parameter int unsigned ENTRY_SHIFT = 3,
    parameter int unsigned VCNT_INIT   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_port,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [1:0]        hdr_port,
    input  logic [11:0]       hdr_vpi,
    input  logic [15:0]       hdr_vci,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_addr,
    output logic              out_cfg_err,
    output logic              out_ovf
);

    port_cfg_t [NPORTS-1:0] cfg_all;
    port_cfg_t              cfg_sel_q;
    logic                   port_bad;
    logic [IDX_MAX-1:0]     key;
    logic                   key_bad;
    logic [ADDR_W-1:0]      sum_addr;
    logic                   sum_carry;
    logic                   any_bad;
    logic                   take;
    out_state_e             state_q;
    out_state_e             state_d;

    lut_cfg_bank #(
        .NPORTS    (NPORTS),
        .VCNT_INIT (VCNT_INIT)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wport (cfg_port),
        .wsel  (cfg_sel),
        .wdata (cfg_wdata),
        .cfg_o (cfg_all)
    );

    always_comb begin
        cfg_sel_q = '0;
        port_bad  = 1'b1;
        for (int p = 0; p < NPORTS; p++) begin
            if (hdr_port == PORT_W'(p)) begin
                cfg_sel_q = cfg_all[p];
                port_bad  = 1'b0;
            end
        end
    end

    lut_key_build u_key (
        .size (cfg_sel_q.size),
        .vcnt (cfg_sel_q.vcnt),
        .vpi  (hdr_vpi),
        .vci  (hdr_vci),
        .key  (key),
        .bad  (key_bad)
    );

    lut_addr_sum #(
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_sum (
        .base  (cfg_sel_q.base),
        .key   (key),
        .addr  (sum_addr),
        .carry (sum_carry)
    );

    assign any_bad   = port_bad || key_bad;
    assign hdr_ready = (state_q == ST_EMPTY) || out_ready;
    assign take      = hdr_valid && hdr_ready;
    assign out_valid = (state_q == ST_FULL);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: T_LOAD, T_STALL, T_REFILL, T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (take) state_d = ST_FULL;
            ST_FULL:  begin
                if (out_ready && !hdr_valid) state_d = ST_EMPTY;
                else                         state_d = ST_FULL;
            end
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr    <= '0;
            out_cfg_err <= 1'b0;
            out_ovf     <= 1'b0;
        end else if (take) begin
            out_cfg_err <= any_bad;
            out_addr    <= any_bad ? '0 : sum_addr;
            out_ovf     <= any_bad ? 1'b0 : sum_carry;
        end
    end

endmodule

// File: rtl/lut_addr_chk.sv
module lut_addr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hdr_valid,
    input logic        hdr_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_addr,
    input logic        out_cfg_err,
    input logic        out_ovf
);

    p_accept_to_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> out_valid);

    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(out_valid)) |-> $past(hdr_valid && hdr_ready));

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                       && $stable(out_cfg_err) && $stable(out_ovf)));

    p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !hdr_ready);

    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cfg_err) |-> (out_addr == 32'd0 && !out_ovf));

endmodule

bind cell_lut_addr_gen lut_addr_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_valid   (hdr_valid),
    .hdr_ready   (hdr_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_addr    (out_addr),
    .out_cfg_err (out_cfg_err),
    .out_ovf     (out_ovf)
);

// File: tb/cell_lut_addr_gen_tb_top.sv
module cell_lut_addr_gen_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_port = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic [1:0]  hdr_port = '0;
    logic [11:0] hdr_vpi = '0;
    logic [15:0] hdr_vci = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic        out_cfg_err;
    logic        out_ovf;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] sh_base [3];
    logic [1:0]  sh_size [3];
    logic [4:0]  sh_vcnt [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    cell_lut_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_port(hdr_port),
        .hdr_vpi(hdr_vpi), .hdr_vci(hdr_vci),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_cfg_err(out_cfg_err), .out_ovf(out_ovf)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected {err, ovf, addr} from the requirements
    function automatic logic [33:0] model(int port, logic [11:0] vpi, logic [15:0] vci);
        logic [19:0] key;
        logic [32:0] sum;
        int w, n;
        if (port > 2) return {1'b1, 1'b0, 32'd0};
        w = 17 + int'(sh_size[port]);
        n = int'(sh_vcnt[port]);
        if (n > 16 || w > n + 12) return {1'b1, 1'b0, 32'd0};
        key = '0;
        for (int i = 0; i < w; i++) begin
            if (i < n) key[i] = vci[i];
            else       key[i] = vpi[i-n];
        end
        sum = {1'b0, sh_base[port]} + {10'd0, key, 3'b000};
        return {1'b0, sum[32], sum[31:0]};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < 3; p++) begin
            sh_base[p] = '0; sh_size[p] = '0; sh_vcnt[p] = 5'd16;
        end
    endtask

    task automatic cfg_write(logic [1:0] port, logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = port; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        if (port < 2'd3) begin
            case (sel)
                2'd0: sh_base[port] = data;
                2'd1: sh_size[port] = data[1:0];
                2'd2: sh_vcnt[port] = data[4:0];
                default: ;
            endcase
        end
    endtask

    task automatic lookup(string req, logic [1:0] port, logic [11:0] vpi, logic [15:0] vci);
        logic [33:0] e;
        @(negedge clk);
        hdr_valid = 1'b1; hdr_port = port; hdr_vpi = vpi; hdr_vci = vci;
        e = model(int'(port), vpi, vci);
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check({req, " addr"},  64'(out_addr), 64'(e[31:0]));
        check({req, " ovf"},   64'(out_ovf), 64'(e[32]));
        check({req, " err"},   64'(out_cfg_err), 64'(e[33]));
    endtask

    task automatic t_reset_state();
        check("R1 out_valid after reset", 64'(out_valid), 64'd0);
        check("R1 hdr_ready after reset", 64'(hdr_ready), 64'd1);
        lookup("R1 default settings", 2'd0, 12'h001, 16'h0002);
        check("R1 default addr value", 64'(out_addr), 64'h80010);
        lookup("R1 default port2", 2'd2, 12'hFFE, 16'hFFFF);
    endtask

    task automatic t_index_layout();
        cfg_write(2'd0, 2'd0, 32'h1000_0000);
        cfg_write(2'd0, 2'd1, 32'd3);
        cfg_write(2'd0, 2'd2, 32'd8);
        lookup("R3 R4 R5 width20 n8", 2'd0, 12'hABC, 16'h1234);
        check("R5 explicit addr", 64'(out_addr), 64'h1055_E1A0);
        cfg_write(2'd1, 2'd1, 32'd1);
        cfg_write(2'd1, 2'd2, 32'd10);
        lookup("R3 R4 width18 n10", 2'd1, 12'h5A5, 16'hC3FF);
        cfg_write(2'd2, 2'd1, 32'd2);
        lookup("R3 width19 n16", 2'd2, 12'hFFF, 16'h8001);
        cfg_write(2'd1, 2'd2, 32'd6);
        lookup("R4 width18 n6 full vpi", 2'd1, 12'hFFF, 16'h0000);
    endtask

    task automatic t_overflow();
        cfg_write(2'd2, 2'd0, 32'hFFFF_FF00);
        cfg_write(2'd2, 2'd1, 32'd0);
        lookup("R6 no carry", 2'd2, 12'h000, 16'h0001);
        lookup("R6 carry", 2'd2, 12'hFFF, 16'hFFFF);
        check("R6 carry flag", 64'(out_ovf), 64'd1);
    endtask

    task automatic t_cfg_errors();
        cfg_write(2'd1, 2'd2, 32'd17);
        lookup("R7 vci count above 16", 2'd1, 12'h123, 16'h4567);
        cfg_write(2'd1, 2'd1, 32'd0);
        cfg_write(2'd1, 2'd2, 32'd4);
        lookup("R7 needs 13 vpi bits", 2'd1, 12'h123, 16'h4567);
        cfg_write(2'd1, 2'd2, 32'd5);
        lookup("R7 exactly 12 vpi bits ok", 2'd1, 12'hFFF, 16'h001F);
        lookup("R7 port code 3", 2'd3, 12'h001, 16'h0001);
    endtask

    task automatic t_ignored_writes();
        cfg_write(2'd3, 2'd0, 32'hDEAD_0000);
        cfg_write(2'd0, 2'd3, 32'hFFFF_FFFF);
        lookup("R2 ignored write port0", 2'd0, 12'h777, 16'h0F0F);
        lookup("R2 ignored write port1", 2'd1, 12'h777, 16'h0F0F);
        lookup("R2 ignored write port2", 2'd2, 12'h001, 16'h0001);
    endtask

    task automatic t_independence();
        cfg_write(2'd1, 2'd0, 32'h0400_0000);
        lookup("R11 port0 untouched", 2'd0, 12'h0AA, 16'h5555);
        lookup("R11 port2 untouched", 2'd2, 12'h000, 16'h0010);
        lookup("R11 port1 updated", 2'd1, 12'h0AA, 16'h5555);
    endtask

    task automatic t_backpressure();
        logic [33:0] e;
        @(negedge clk);
        out_ready = 1'b0;
        hdr_valid = 1'b1; hdr_port = 2'd0; hdr_vpi = 12'h321; hdr_vci = 16'hABCD;
        e = model(0, 12'h321, 16'hABCD);
        @(posedge clk);
        @(negedge clk);
        hdr_vpi = 12'h999; hdr_vci = 16'h1111;
        for (int k = 0; k < 3; k++) begin
            check("R9 held valid", 64'(out_valid), 64'd1);
            check("R9 held addr", 64'(out_addr), 64'(e[31:0]));
            check("R9 hdr_ready low", 64'(hdr_ready), 64'd0);
            @(posedge clk);
            @(negedge clk);
        end
        hdr_valid = 1'b0;
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 drained", 64'(out_valid), 64'd0);
    endtask

    task automatic t_stream();
        logic [11:0] vp [4];
        logic [15:0] vc [4];
        logic [33:0] e;
        for (int k = 0; k < 4; k++) begin
            vp[k] = 12'(12'h100 * k + 7);
            vc[k] = 16'(16'h1357 * (k + 1));
        end
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            hdr_valid = 1'b1; hdr_port = 2'(k % 3); hdr_vpi = vp[k]; hdr_vci = vc[k];
            check("R10 ready each cycle", 64'(hdr_ready), 64'd1);
            e = model(k % 3, vp[k], vc[k]);
            @(posedge clk);
            @(negedge clk);
            check("R10 stream valid", 64'(out_valid), 64'd1);
            check("R10 stream addr", 64'(out_addr), 64'(e[31:0]));
            check("R10 stream err", 64'(out_cfg_err), 64'(e[33]));
        end
        hdr_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R8 valid drops when idle", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_index_layout();
        t_overflow();
        t_cfg_errors();
        t_ignored_writes();
        t_independence();
        t_backpressure();
        t_stream();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule